// File: doc/BRIEF.md
# Pairwise Interaction Force Accumulator

This block is the summing and sequencing back end of a pairwise-interaction engine. An upstream arithmetic pipeline delivers one interaction term per clock for the i-particle held in its registers. Each term carries three force components. Each component is a signed fixed-point value in sign-magnitude form and is narrower than the running sum. The block converts every component to two's complement and adds it into a 64-bit register for that component, through an accumulate path of configurable depth.

A host starts a pass with a one-cycle run pulse that also carries the term count n. The pulse zeroes the three sums. The block then accepts valid terms until n of them have been taken. It raises a one-cycle completion pulse once the last term has left its internal stages and reached the sums. After that pulse the host reads each sum as two 32-bit words through a small word address. The sums hold their value until the next run pulse.

Top module: `force_accum`

## Requirements
- R1: After a synchronous reset, done_o is low and every readout word is zero.
- R2: A run pulse zeroes all three sums and abandons terms still in flight. A term presented in the run cycle itself is not accepted.
- R3: Component k of term_i sits at bits [57k+56:57k]. Bit 57k+56 is its sign and the 56 bits below it are its magnitude. The magnitude is added to sum k when the sign is 0 and subtracted when it is 1.
- R4: A term is accepted only in a cycle with term_vld_i high, after a run pulse and before n terms have been taken. Idle gaps between terms are allowed.
- R5: done_o is high for exactly one cycle. With S accumulate stages, it rises S-1 clock edges after the edge that accepts the n-th term. In that cycle the readout already shows the final sums.
- R6: A run pulse with n = 0 raises done_o on the next cycle, and the sums read zero.
- R7: Readout is combinational. Address 2k returns bits [31:0] of sum k and address 2k+1 returns bits [63:32]. Addresses 6 to 15 return zero.
- R8: The sums wrap modulo 2^64 without saturation.
- R9: A run pulse during an active pass restarts it. The abandoned pass produces no done_o.
- R10: Valid terms presented after a pass has completed leave the sums unchanged until the next run pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | One-cycle pass start; clears the sums |
| n_terms_i | input | 16 | Number of terms in the pass, sampled with run_i |
| term_vld_i | input | 1 | term_i carries a valid term this cycle |
| term_i | input | 171 | Three sign-magnitude components, 57 bits each |
| done_o | output | 1 | One-cycle pulse when the pass result is final |
| rd_addr_i | input | 4 | Readout word address |
| rd_data_o | output | 32 | Readout word |

## Verification
The bench builds the block with its defaults: 57-bit terms, 64-bit sums, three components and two accumulate stages. The two stages put a real delay between the accepted term and done_o, so the bench can check the completion cycle against a count it derives itself. The full 56-bit magnitude lets a 300-term pass of near-maximum values wrap the 64-bit sum. The 4-bit address leaves ten unused word addresses to probe. The passes cover gaps, trailing surplus terms, n = 0 and a restart in the middle of a pass.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned RD_W = 32;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/fa_ctrl.sv
module fa_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] n_terms,
  input  logic             term_vld,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] n_lat,
  output logic             accept,
  output logic             last,
  output logic             empty_run
);
  assign accept    = busy && term_vld;
  assign last      = accept && (cnt == n_lat - CNT_W'(1));
  assign empty_run = run && (n_terms == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      n_lat <= '0;
    end else if (run) begin
      busy  <= (n_terms != '0);
      cnt   <= '0;
      n_lat <= n_terms;
    end else if (accept) begin
      cnt <= cnt + CNT_W'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/fa_accum.sv
module fa_accum #(
  parameter int TERM_W = 57,
  parameter int ACC_W  = 64,
  parameter int NCOMP  = 3,
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    accept,
  input  logic                    last,
  input  logic                    empty_run,
  input  logic [NCOMP*TERM_W-1:0] term,
  output logic [NCOMP*ACC_W-1:0]  sums,
  output logic                    out_val,
  output logic                    done
);
  localparam int MAG_W = TERM_W - 1;
  localparam int VEC_W = NCOMP * ACC_W;

  function automatic logic [ACC_W-1:0] sm_to_tc(input logic neg, input logic [MAG_W-1:0] mag);
    logic [ACC_W-1:0] m;
    m = ACC_W'(mag);
    return neg ? (~m + ACC_W'(1)) : m;
  endfunction

  logic [VEC_W-1:0] conv;
  for (genvar c = 0; c < NCOMP; c++) begin : g_conv
    assign conv[c*ACC_W +: ACC_W] = sm_to_tc(term[c*TERM_W + MAG_W], term[c*TERM_W +: MAG_W]);
  end

  logic             out_last;
  logic [VEC_W-1:0] out_term;

  if (STAGES == 1) begin : g_direct
    assign out_val  = accept;
    assign out_last = last;
    assign out_term = conv;
  end else begin : g_pipe
    logic [STAGES-2:0] v_q;
    logic [STAGES-2:0] l_q;
    logic [VEC_W-1:0]  t_q [STAGES-1];
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        v_q <= '0;
        l_q <= '0;
      end else begin
        for (int k = STAGES - 2; k > 0; k--) begin
          v_q[k] <= v_q[k-1];
          l_q[k] <= l_q[k-1];
        end
        v_q[0] <= accept;
        l_q[0] <= last;
      end
      for (int k = STAGES - 2; k > 0; k--) t_q[k] <= t_q[k-1];
      t_q[0] <= conv;
    end
    assign out_val  = v_q[STAGES-2];
    assign out_last = l_q[STAGES-2];
    assign out_term = t_q[STAGES-2];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sums <= '0;
    end else if (out_val) begin
      for (int c = 0; c < NCOMP; c++)
        sums[c*ACC_W +: ACC_W] <= sums[c*ACC_W +: ACC_W] + out_term[c*ACC_W +: ACC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= empty_run || (!clear && out_val && out_last);
  end
endmodule

// File: rtl/fa_rdmux.sv
module fa_rdmux import fa_pkg::*; #(
  parameter int ACC_W  = 64,
  parameter int NCOMP  = 3,
  parameter int ADDR_W = 4
) (
  input  logic [NCOMP*ACC_W-1:0] sums,
  input  logic [ADDR_W-1:0]      addr,
  output logic [RD_W-1:0]        data
);
  localparam int WPA   = int'(ceil_div(ACC_W, RD_W));
  localparam int WORDS = NCOMP * WPA;

  logic [WORDS*RD_W-1:0] pad;
  for (genvar c = 0; c < NCOMP; c++) begin : g_pad
    assign pad[c*WPA*RD_W +: WPA*RD_W] = (WPA*RD_W)'(sums[c*ACC_W +: ACC_W]);
  end

  always_comb begin
    data = '0;
    if (int'(addr) < WORDS) data = pad[int'(addr)*RD_W +: RD_W];
  end
endmodule

// File: rtl/force_accum.sv
module force_accum import fa_pkg::*; #(
  parameter int TERM_W     = 57,
  parameter int ACC_W      = 64,
  parameter int NCOMP      = 3,
  parameter int ACC_STAGES = 2,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_i,
  input  logic [CNT_W-1:0]        n_terms_i,
  input  logic                    term_vld_i,
  input  logic [NCOMP*TERM_W-1:0] term_i,
  output logic                    done_o,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [RD_W-1:0]         rd_data_o
);
  // Named internal events, also observed by the bound checker
  logic                   busy_w;
  logic [CNT_W-1:0]       cnt_w;
  logic [CNT_W-1:0]       nlat_w;
  logic                   accept_w;
  logic                   last_w;
  logic                   empty_w;
  logic                   out_val_w;
  logic [NCOMP*ACC_W-1:0] sums_w;

  fa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .run(run_i), .n_terms(n_terms_i), .term_vld(term_vld_i),
    .busy(busy_w), .cnt(cnt_w), .n_lat(nlat_w),
    .accept(accept_w), .last(last_w), .empty_run(empty_w)
  );

  fa_accum #(.TERM_W(TERM_W), .ACC_W(ACC_W), .NCOMP(NCOMP), .STAGES(ACC_STAGES)) u_acc (
    .clk(clk), .rst(rst), .clear(run_i), .accept(accept_w), .last(last_w),
    .empty_run(empty_w), .term(term_i), .sums(sums_w), .out_val(out_val_w), .done(done_o)
  );

  fa_rdmux #(.ACC_W(ACC_W), .NCOMP(NCOMP), .ADDR_W(ADDR_W)) u_rd (
    .sums(sums_w), .addr(rd_addr_i), .data(rd_data_o)
  );
endmodule

// File: rtl/force_accum_chk.sv
module fa_force_chk #(
  parameter int CNT_W  = 16,
  parameter int VEC_W  = 192,
  parameter int ADDR_W = 4,
  parameter int WORDS  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              busy,
  input logic              out_val,
  input logic              done,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  n_lat,
  input logic [VEC_W-1:0]  sums,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!done && sums == '0));

  p_clear_on_run_r2: assert property (@(posedge clk) disable iff (rst)
    run |=> (sums == '0));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < n_lat));

  p_done_after_pass_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !run) |=> !done);

  p_unused_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= WORDS) |-> (rd_data == '0));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!run && !out_val) |=> $stable(sums));
endmodule

bind force_accum fa_force_chk #(
  .CNT_W(CNT_W), .VEC_W(NCOMP*ACC_W), .ADDR_W(ADDR_W), .WORDS(NCOMP*((ACC_W+31)/32))
) u_chk (
  .clk(clk), .rst(rst), .run(run_i), .busy(busy_w), .out_val(out_val_w), .done(done_o),
  .cnt(cnt_w), .n_lat(nlat_w), .sums(sums_w), .rd_addr(rd_addr_i), .rd_data(rd_data_o)
);

// File: tb/tb_force_accum.sv
module tb_force_accum;
  localparam int TW = 57, AW = 64, NC = 3, STG = 2, CW = 16, ADW = 4;
  localparam logic [56:0] JUNK = 57'h1ABCDEF12345678;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, vld = 1'b0;
  logic [CW-1:0] nt = '0;
  logic [NC*TW-1:0] term = '0;
  logic done;
  logic [ADW-1:0] rd_addr = '0;
  logic [31:0] rd_data;

  force_accum #(.TERM_W(TW), .ACC_W(AW), .NCOMP(NC), .ACC_STAGES(STG), .CNT_W(CW), .ADDR_W(ADW)) dut (
    .clk(clk), .rst(rst), .run_i(run), .n_terms_i(nt), .term_vld_i(vld), .term_i(term),
    .done_o(done), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit mon_on = 0, ended = 0, prev_done = 0;
  string cur_req = "R3";

  typedef struct packed {
    logic [NC*AW-1:0] s;
    int               due;
  } exp_t;
  exp_t q[$];
  exp_t mit;
  logic [NC*AW-1:0] last_sums = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Sign-magnitude component to a 64-bit signed contribution
  function automatic logic [63:0] contrib(input logic [56:0] t);
    logic [63:0] m;
    m = {8'd0, t[55:0]};
    return t[56] ? (64'd0 - m) : m;
  endfunction

  function automatic logic [56:0] make_term(input int i, input int pat, input int c);
    logic [55:0] m;
    logic s;
    case (pat)
      0: begin m = 56'(i * 7 + c * 13 + 1); s = ((i + c) % 2) == 1; end
      1: begin m = {56{1'b1}} - 56'(i); s = (c == 1); end
      default: begin
        m = 56'(64'h9E3779B97F4A7C15 * 64'(i + 1)) ^ 56'(c * 977);
        s = (i % 3) == c;
      end
    endcase
    return {s, m};
  endfunction

  task automatic start_run(input int n);
    @(negedge clk);
    run = 1'b1; nt = CW'(n);
    vld = 1'b1; term = {NC{JUNK}};   // R2: term in the run cycle must be dropped
  endtask

  task automatic pass(input int n, input int pat, input int gap, input int extra);
    logic [NC*AW-1:0] e;
    int rc, lc;
    exp_t it;
    e = '0; lc = 0;
    start_run(n);
    rc = cyc;
    if (n == 0) begin it.s = '0; it.due = rc + 1; q.push_back(it); end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); run = 1'b0;
      if (gap != 0 && (i % gap) == gap - 1) begin
        vld = 1'b0; term = {NC{JUNK}};
        @(negedge clk);
      end
      vld = 1'b1;
      for (int c = 0; c < NC; c++) begin
        term[c*TW +: TW] = make_term(i, pat, c);
        e[c*AW +: AW] = e[c*AW +: AW] + contrib(make_term(i, pat, c));
      end
      lc = cyc;
    end
    if (n > 0) begin it.s = e; it.due = lc + STG; q.push_back(it); end
    for (int x = 0; x < extra; x++) begin
      @(negedge clk); run = 1'b0; vld = 1'b1; term = {NC{JUNK}};
    end
    @(negedge clk); run = 1'b0; vld = 1'b0;
    last_sums = e;
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops the expected pass result when done_o appears
  always @(negedge clk) begin
    if (mon_on) begin
      if (done && prev_done) chk(1'b0, "R5", 64'd1, 64'd0, "done_o held two cycles");
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", 64'd1, 64'd0, "done_o with no pass pending");
        end else begin
          mit = q.pop_front();
          chk(cyc == mit.due, "R5", 64'(cyc), 64'(mit.due), "done_o cycle");
          for (int w = 0; w < NC * 2; w++) begin
            rd_addr = ADW'(w);
            #1;
            chk(rd_data == mit.s[w*32 +: 32], cur_req, 64'(rd_data), 64'(mit.s[w*32 +: 32]), "R7 readout word");
          end
          rd_addr = '0;
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1", 64'(done), 64'd0, "done after reset");
    for (int a = 0; a < 16; a++) begin
      rd_addr = ADW'(a); #1;
      chk(rd_data == 32'd0, "R1", 64'(rd_data), 64'd0, "word after reset");
    end
    rd_addr = '0;
    mon_on = 1;

    cur_req = "R3";  pass(5, 0, 0, 0);
    cur_req = "R4";  pass(12, 2, 3, 0);
    cur_req = "R10"; pass(6, 2, 0, 4);

    // R10: valid terms while idle must not move the sums
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); vld = 1'b1; term = {NC{JUNK}};
    end
    @(negedge clk); vld = 1'b0;
    repeat (3) @(negedge clk);
    for (int w = 0; w < NC * 2; w++) begin
      rd_addr = ADW'(w); #1;
      chk(rd_data == last_sums[w*32 +: 32], "R10", 64'(rd_data), 64'(last_sums[w*32 +: 32]), "idle hold");
    end
    // R7: unused addresses read zero while sums are nonzero
    for (int a = NC * 2; a < 16; a++) begin
      rd_addr = ADW'(a); #1;
      chk(rd_data == 32'd0, "R7", 64'(rd_data), 64'd0, "unused address");
    end
    rd_addr = '0;

    cur_req = "R2";  pass(3, 2, 0, 0);
    cur_req = "R6";  pass(0, 0, 0, 0);
    cur_req = "R8";  pass(300, 1, 0, 0);

    // R9: abandon a pass midway, then restart
    start_run(10);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); run = 1'b0; vld = 1'b1;
      for (int c = 0; c < NC; c++) term[c*TW +: TW] = make_term(i, 1, c);
    end
    cur_req = "R9";  pass(3, 0, 0, 0);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R9", 64'(q.size()), 64'd0, "pending passes at end");
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule